// File: doc/BRIEF.md
# Byte-Stream Register Processor Core

This block is a small multi-cycle processor. It reads byte-wide instructions from an internal 256-byte memory and runs them one after another. It holds eight 8-bit general registers and an 8-bit program counter. The program counter starts at address 0 after reset.

The core knows four instructions: load a register with an immediate, multiply one register by another, emit a register value on the print port, and stop. The top two bits of every opcode give the number of operand bytes that follow. The program counter moves past the opcode and its operands. The memory reads synchronously, so every byte fetch takes a cycle of its own.

A program is written through a preload port while reset is held. It is placed from address 0 upward. When reset is released, execution begins at address 0. It continues until a stop instruction or an unknown opcode halts the core. Only the next reset restarts it.

Top module: `octet_core`

## Requirements
- R1: While reset is high and after it, the core has cleared all eight registers, set the program counter to 0, and driven out_valid, halted and fault low. A program that prints a register it has not written prints 0.
- R2: Opcode 0x82 is followed by a register-index byte and an immediate byte, and it writes the immediate into that register.
- R3: Opcode 0xA2 is followed by register-index bytes A then B. It writes the low 8 bits of A×B into register A. A and B may name the same register.
- R4: Opcode 0x47 is followed by one register-index byte. It raises out_valid for exactly one cycle, with out_data equal to that register's value.
- R5: Opcode 0x01 raises halted. halted stays high until reset, and no later instruction produces output.
- R6: Any opcode other than 0x82, 0xA2, 0x47 and 0x01 raises both halted and fault. Execution stops with no further output.
- R7: Opcode bits [7:6] give the operand count, and the program counter advances by that count plus one. Program counter arithmetic and operand addresses wrap modulo 256.
- R8: Only bits [2:0] of a register-index byte select the register. For example, 0xF9 and 0x09 both name register 1.
- R9: Counted from the first clock edge with reset low, 0x82 and 0xA2 take 5 cycles, 0x47 takes 4 cycles, and 0x01 or an unknown opcode raises halted in its 2nd cycle. For the program "0x82 0x00 0x08, 0x47 0x00, 0x01", the print is seen after edge 9 and halted after edge 11.
- R10: With load_we high at a clock edge, load_data is written into memory at load_addr, and the core later fetches it from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Preload write enable |
| load_addr | input | AW (8) | Preload byte address |
| load_data | input | 8 | Preload byte value |
| out_valid | output | 1 | One-cycle print strobe |
| out_data | output | 8 | Printed register value |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on an unknown opcode |

## Verification
Each instruction has a fixed latency. Because of that, the bench counts clock edges from reset release and predicts the exact edge on which each print strobe and the halt flag must appear: 5 cycles per load or multiply, 4 per print, and 2 for a stop. It samples on the falling edge after that rising edge. It checks the cycle number of each recorded event as well as its value. The multiply vector table checks each print at edge 19 and the halt at edge 21. The wrap-around program checks that the halt arrives at edge 438, after 88 instructions.

// File: rtl/octet_pkg.sv
package octet_pkg;
  localparam int WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t OPC_LOAD = 8'h82;
  localparam word_t OPC_MUL  = 8'hA2;
  localparam word_t OPC_SHOW = 8'h47;
  localparam word_t OPC_STOP = 8'h01;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_ARG_A, ST_ARG_B, ST_EXEC, ST_HALT
  } phase_t;

  typedef enum logic [2:0] {
    ACT_BAD, ACT_STOP, ACT_LOAD, ACT_MUL, ACT_SHOW
  } action_t;

  function automatic logic [1:0] arg_count(word_t opc);
    return opc[WORD_W-1:WORD_W-2];
  endfunction

  function automatic action_t classify(word_t opc);
    action_t a;
    case (opc)
      OPC_LOAD: a = ACT_LOAD;
      OPC_MUL:  a = ACT_MUL;
      OPC_SHOW: a = ACT_SHOW;
      OPC_STOP: a = ACT_STOP;
      default:  a = ACT_BAD;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/octet_mem.sv
module octet_mem #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/octet_regs.sv
module octet_regs #(
  parameter int NREG = 8,
  parameter int W    = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] widx,
  input  logic [W-1:0]   wdata,
  input  logic [RIW-1:0] ra_idx,
  output logic [W-1:0]   ra_data,
  input  logic [RIW-1:0] rb_idx,
  output logic [W-1:0]   rb_data
);
  logic [W-1:0]    file_q [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign hit[g] = we && (widx == RIW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)         file_q[i] <= '0;
      else if (hit[i]) file_q[i] <= wdata;
    end
  end

  assign ra_data = file_q[ra_idx];
  assign rb_data = file_q[rb_idx];
endmodule

// File: rtl/octet_alu.sv
module octet_alu
  import octet_pkg::*;
#(
  parameter int W = 8
) (
  input  action_t      act,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res
);
  always_comb begin
    case (act)
      ACT_MUL: res = a * b;   // truncated to W bits by context
      default: res = imm;
    endcase
  end
endmodule

// File: rtl/octet_ctrl.sv
module octet_ctrl
  import octet_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NREG = 8,
  parameter int W    = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  mem_raddr,
  input  logic [W-1:0]   mem_rdata,
  output logic [RIW-1:0] ra_idx,
  output logic [RIW-1:0] rb_idx,
  input  logic [W-1:0]   ra_data,
  output action_t        act,
  output logic [W-1:0]   imm,
  output logic           rf_we,
  output logic [RIW-1:0] rf_widx,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           halted,
  output logic           fault,
  output logic [AW-1:0]  pc,
  output logic           exec_go
);
  phase_t         phase_q;
  action_t        act_q;
  logic [1:0]     cnt_q;
  logic [RIW-1:0] arg_a_q;
  logic [W-1:0]   arg_b_q;
  logic [AW-1:0]  pc_q;
  logic           valid_q, halt_q, fault_q;
  logic [W-1:0]   data_q;
  action_t        dec_act;

  assign dec_act = classify(mem_rdata);

  // address of the byte that the next phase consumes
  always_comb begin
    case (phase_q)
      ST_DECODE: mem_raddr = pc_q + AW'(1);
      ST_ARG_A:  mem_raddr = pc_q + AW'(2);
      default:   mem_raddr = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_FETCH;
      act_q   <= ACT_BAD;
      cnt_q   <= '0;
      arg_a_q <= '0;
      arg_b_q <= '0;
      pc_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      halt_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (phase_q)
        ST_FETCH: phase_q <= ST_DECODE;
        ST_DECODE: begin
          act_q <= dec_act;
          cnt_q <= arg_count(mem_rdata);
          if (dec_act == ACT_BAD) begin
            phase_q <= ST_HALT;
            halt_q  <= 1'b1;
            fault_q <= 1'b1;
          end else if (dec_act == ACT_STOP) begin
            phase_q <= ST_HALT;
            halt_q  <= 1'b1;
          end else begin
            phase_q <= ST_ARG_A;
          end
        end
        ST_ARG_A: begin
          arg_a_q <= mem_rdata[RIW-1:0];
          phase_q <= (cnt_q == 2'd2) ? ST_ARG_B : ST_EXEC;
        end
        ST_ARG_B: begin
          arg_b_q <= mem_rdata;
          phase_q <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q <= pc_q + AW'(cnt_q) + AW'(1);
          if (act_q == ACT_SHOW) begin
            valid_q <= 1'b1;
            data_q  <= ra_data;
          end
          phase_q <= ST_FETCH;
        end
        default: phase_q <= ST_HALT;
      endcase
    end
  end

  assign ra_idx    = arg_a_q;
  assign rb_idx    = arg_b_q[RIW-1:0];
  assign act       = act_q;
  assign imm       = arg_b_q;
  assign exec_go   = (phase_q == ST_EXEC);
  assign rf_we     = exec_go && (act_q == ACT_LOAD || act_q == ACT_MUL);
  assign rf_widx   = arg_a_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign halted    = halt_q;
  assign fault     = fault_q;
  assign pc        = pc_q;
endmodule

// File: rtl/octet_core.sv
module octet_core
  import octet_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [AW-1:0]     load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              halted,
  output logic              fault
);
  localparam int RIW = $clog2(NREG);

  logic [AW-1:0]     mem_raddr;
  logic [WORD_W-1:0] mem_rdata;
  logic [RIW-1:0]    ra_idx, rb_idx, rf_widx;
  logic [WORD_W-1:0] ra_data, rb_data, imm, wb_data;
  logic              rf_we;
  action_t           act;
  logic [AW-1:0]     pc_w;
  logic              exec_w;

  octet_mem #(.AW(AW), .W(WORD_W)) mem_i (
    .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  octet_regs #(.NREG(NREG), .W(WORD_W)) regs_i (
    .clk(clk), .rst(rst), .we(rf_we), .widx(rf_widx), .wdata(wb_data),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data)
  );

  octet_alu #(.W(WORD_W)) alu_i (
    .act(act), .a(ra_data), .b(rb_data), .imm(imm), .res(wb_data)
  );

  octet_ctrl #(.AW(AW), .NREG(NREG), .W(WORD_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_data(ra_data),
    .act(act), .imm(imm), .rf_we(rf_we), .rf_widx(rf_widx),
    .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .fault(fault),
    .pc(pc_w), .exec_go(exec_w)
  );
endmodule

// File: rtl/octet_core_chk.sv
module octet_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          halted,
  input logic          fault,
  input logic [AW-1:0] pc,
  input logic          exec_go
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !halted && !fault));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_print_after_exec_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(exec_go));

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);

  assert_fault_halts_R6: assert property (@(posedge clk) disable iff (rst)
    fault |-> halted);

  assert_pc_moves_on_exec_R7: assert property (@(posedge clk) disable iff (rst)
    !exec_go |=> $stable(pc));
endmodule

bind octet_core octet_core_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .halted(halted),
  .fault(fault), .pc(pc_w), .exec_go(exec_w)
);

// File: tb/octet_core_tb.sv
`timescale 1ns/1ps
module octet_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_we = 1'b0;
  logic [7:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       out_valid, halted, fault;
  logic [7:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] img [256];
  logic [7:0] got [64];
  int         got_cyc [64];
  int         n_got;
  int         halt_cyc;

  // a, b, expected low byte of a*b
  localparam logic [23:0] VEC [6] = '{
    24'h03_05_0F, 24'h14_0D_04, 24'hFF_FF_01,
    24'h10_10_00, 24'h00_7B_00, 24'h07_09_3F
  };

  always #2.5 clk = ~clk;

  octet_core dut_i (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .fault(fault)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic blank();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  // preload under reset (R10), then release and record events per cycle
  task automatic run(int limit);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      load_we = 1'b1; load_addr = 8'(i); load_data = img[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "halted in reset", int'(halted), 0);
    chk("R1", "fault in reset", int'(fault), 0);
    rst = 1'b0;
    n_got = 0;
    halt_cyc = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (out_valid && n_got < 64) begin
        got[n_got] = out_data; got_cyc[n_got] = c; n_got++;
      end
      if (halted && halt_cyc < 0) halt_cyc = c;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // vector table: R3 truncated multiply, R2 loads, R4 print, R9 timing
    for (int v = 0; v < 6; v++) begin
      blank();
      img[0] = 8'h82; img[1] = 8'h01; img[2]  = VEC[v][23:16];
      img[3] = 8'h82; img[4] = 8'h06; img[5]  = VEC[v][15:8];
      img[6] = 8'hA2; img[7] = 8'h01; img[8]  = 8'h06;
      img[9] = 8'h47; img[10] = 8'h01; img[11] = 8'h01;
      run(30);
      chk("R3", "print count", n_got, 1);
      chk("R3", "product", int'(got[0]), int'(VEC[v][7:0]));
      chk("R9", "print cycle", got_cyc[0], 19);
      chk("R5", "halt cycle", halt_cyc, 21);
    end

    // R9 R2 R4: LDI R0,8; PRN R0; HLT
    blank();
    img[0] = 8'h82; img[1] = 8'h00; img[2] = 8'h08;
    img[3] = 8'h47; img[4] = 8'h00; img[5] = 8'h01;
    run(25);
    chk("R4", "single pulse", n_got, 1);
    chk("R2", "loaded value", int'(got[0]), 8);
    chk("R9", "print edge", got_cyc[0], 9);
    chk("R9", "halt edge", halt_cyc, 11);
    chk("R6", "no fault on stop", int'(fault), 0);

    // R1: registers cleared by the reset between runs
    blank();
    img[0] = 8'h82; img[1] = 8'h03; img[2] = 8'h55; img[3] = 8'h01;
    run(15);
    blank();
    img[0] = 8'h47; img[1] = 8'h03; img[2] = 8'h01;
    run(15);
    chk("R1", "cleared register", int'(got[0]), 0);
    chk("R9", "print-first edge", got_cyc[0], 4);

    // R8 index bits, R3 squaring with aliased indices
    blank();
    img[0] = 8'h82; img[1] = 8'hF9; img[2] = 8'h2A;
    img[3] = 8'h47; img[4] = 8'h01;
    img[5] = 8'h47; img[6] = 8'h09;
    img[7] = 8'hA2; img[8] = 8'h09; img[9] = 8'hF9;
    img[10] = 8'h47; img[11] = 8'h01; img[12] = 8'h01;
    run(40);
    chk("R8", "print count", n_got, 3);
    chk("R8", "alias 0x01", int'(got[0]), 8'h2A);
    chk("R8", "alias 0x09", int'(got[1]), 8'h2A);
    chk("R3", "square", int'(got[2]), 8'hE4);

    // R5: nothing after stop
    blank();
    img[0] = 8'h01; img[1] = 8'h47; img[2] = 8'h00;
    run(40);
    chk("R5", "halt edge", halt_cyc, 2);
    chk("R5", "no print after stop", n_got, 0);
    chk("R5", "still halted", int'(halted), 1);

    // R6: unknown opcode 0x00 after a print
    blank();
    img[0] = 8'h82; img[1] = 8'h00; img[2] = 8'h05;
    img[3] = 8'h47; img[4] = 8'h00;
    img[5] = 8'h00; img[6] = 8'h47; img[7] = 8'h00;
    run(40);
    chk("R6", "prints before fault", n_got, 1);
    chk("R6", "printed value", int'(got[0]), 5);
    chk("R6", "halt edge", halt_cyc, 11);
    chk("R6", "fault flag", int'(fault), 1);

    // R6: count field says zero but opcode unknown
    blank();
    img[0] = 8'h03;
    run(10);
    chk("R6", "fault on 0x03", int'(fault), 1);
    chk("R6", "halt on 0x03", halt_cyc, 2);

    // R7 wrap: LDI at 0xFF takes operands from 0x00 and 0x01, PC lands on 0x02
    blank();
    img[0] = 8'h82; img[1] = 8'h05; img[2] = 8'h47;
    for (int k = 0; k < 82; k++) begin
      img[3 + 3*k] = 8'h82; img[4 + 3*k] = 8'h01; img[5 + 3*k] = 8'h00;
    end
    img[249] = 8'h47; img[250] = 8'h05;
    img[251] = 8'h47; img[252] = 8'h05;
    img[253] = 8'h47; img[254] = 8'h05;
    img[255] = 8'h82;
    run(460);
    chk("R7", "print count", n_got, 4);
    chk("R7", "first print", int'(got[0]), 8'h47);
    chk("R7", "third print", int'(got[2]), 8'h47);
    chk("R7", "wrapped load", int'(got[3]), 8'h05);
    chk("R9", "wrapped print edge", got_cyc[3], 436);
    chk("R7", "halt edge", halt_cyc, 438);
    chk("R7", "no fault", int'(fault), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule